// File: doc/BRIEF.md
# Priority Filter Lookup Engine

This block is the classification stage of a packet path. It holds a parameterised number of ternary filter entries. Each entry has a stored value, a care mask, an enable flag and a result word. A 144-bit lookup key arrives with a ready/valid handshake and is compared against every enabled entry in parallel. The result of the matching entry with the smallest index is returned on a second ready/valid interface, together with the 12 exception bits that came with the key. A key that matches no enabled entry is dropped. The drop is signalled by a one-cycle pulse in the slot where the result would have appeared.

The top 32 key bits carry a substrate tag. From the most significant bit down, the tag holds a 1-bit lookup type, a 4-bit receive ID, an 11-bit slice number and a 16-bit received UDP destination port. The 112 bits below the tag are free for the user. The exception path builds its key from the tag followed by an all-zero user field. The engine treats that key like any other.

Software changes the table through a single-cycle write port. One write can load an entry's value and care mask (which enables the entry), replace its result word, or disable it. Disabling an entry leaves its stored result in place. Lookups keep their order and take a fixed two-stage path. Each lookup sees the table as it stood on the clock edge that accepted it.

Top module: `lkp_prio_lookup`

## Requirements
- R1: An entry matches a key when its enable flag is set and every key bit whose care-mask bit is 1 equals the stored value bit; key bits whose care bit is 0 are ignored.
- R2: When several enabled entries match, the output carries the result of the entry with the lowest index.
- R3: A key with no matching entry produces no result beat; instead rs_drop is high for one cycle, in the cycle a result would have been valid; rs_drop and rs_valid are never high together.
- R4: A result beat carries rs_mc (0 = unicast, 1 = multicast), a 31-bit result index and a 16-bit stats index exactly as stored; rs_cmask carries the stored 16-bit copy mask for multicast results and is all zero for unicast results.
- R5: The 12 exception bits accepted with a key appear unchanged on rs_exc with that key's result.
- R6: With rs_ready high, a key accepted on clock edge E gives rs_valid or rs_drop after edge E+1 and neither after edge E alone; results leave in the order keys were accepted.
- R7: While rs_valid is high and rs_ready is low, every result output holds steady; lk_ready falls once both pipeline stages are occupied.
- R8: cfg_op encodings: 2'b01 loads value and care mask and enables the entry, leaving its result; 2'b10 replaces the result word, leaving value, mask and enable; 2'b11 clears the enable flag, leaving value, mask and result; 2'b00 does nothing.
- R9: A table write on the same clock edge that accepts a key does not affect that key's lookup; keys accepted on later edges see the write.
- R10: A key made of the substrate tag (bits 143..112) followed by an all-zero user field is looked up normally, so an entry that cares only about the tag bits catches it.
- R11: After reset all entries are disabled, rs_valid and rs_drop are low, and lk_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_op | input | 2 | Write operation (see R8) |
| cfg_addr | input | ADDR_W | Entry index; values at or above NUM_ENTRIES are ignored |
| cfg_value | input | KEY_W | Stored match value |
| cfg_care | input | KEY_W | Care mask, 1 = bit compared |
| cfg_res_mc | input | 1 | Result type, 1 = multicast |
| cfg_res_idx | input | 31 | Result index |
| cfg_res_cmask | input | 16 | Multicast copy mask |
| cfg_res_stat | input | 16 | Stats index |
| lk_valid | input | 1 | Key valid |
| lk_ready | output | 1 | Key accepted when high with lk_valid |
| lk_key | input | KEY_W | Lookup key, tag in bits 143..112 |
| lk_exc | input | EXC_W | Exception bits carried with the key |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_mc | output | 1 | Result type, 1 = multicast |
| rs_idx | output | 31 | Result index |
| rs_cmask | output | 16 | Copy mask, zero for unicast |
| rs_stat | output | 16 | Stats index |
| rs_exc | output | EXC_W | Exception bits of the key |
| rs_drop | output | 1 | One-cycle pulse for a dropped (missed) key |

## Verification
The effect of a corrupted enable flag, value or care bit depends on where the key falls. It shows as a drop pulse where a result was due, or as a result from the wrong index, on the second edge after the key is accepted. A priority encoder that picks the wrong entry shows up only for keys that match several entries at once. The bench therefore sweeps every subset of matching entries in an eight-entry table. A pipeline slot left stale shows as a held beat that changes under backpressure, a lost or repeated beat, or a result that reflects a table write made on the edge that accepted the key.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

   localparam int unsigned RIDX_W  = 31;
   localparam int unsigned CMASK_W = 16;
   localparam int unsigned STAT_W  = 16;

   typedef struct packed {
      logic               mc;
      logic [RIDX_W-1:0]  ridx;
      logic [CMASK_W-1:0] cmask;
      logic [STAT_W-1:0]  stat;
   } lkp_result_t;

   typedef enum logic [1:0] {
      CFG_NOP     = 2'b00,
      CFG_KEY     = 2'b01,
      CFG_RESULT  = 2'b10,
      CFG_DISABLE = 2'b11
   } cfg_op_e;

endpackage

// File: rtl/lkp_ternary_cell.sv
module lkp_ternary_cell
   import lkp_pkg::*;
#(
   parameter int unsigned KEY_W = 144
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_key,
   input  logic             sel_res,
   input  logic             sel_off,
   input  logic [KEY_W-1:0] wr_value,
   input  logic [KEY_W-1:0] wr_care,
   input  lkp_result_t      wr_res,
   input  logic [KEY_W-1:0] key,
   output logic             hit,
   output lkp_result_t      res
);

   logic             on_q;
   logic [KEY_W-1:0] val_q;
   logic [KEY_W-1:0] care_q;
   lkp_result_t      res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         val_q  <= '0;
         care_q <= '0;
         res_q  <= '0;
      end else begin
         if (sel_key) begin
            val_q  <= wr_value;
            care_q <= wr_care;
            on_q   <= 1'b1;
         end else if (sel_off) begin
            on_q <= 1'b0;
         end
         if (sel_res) begin
            res_q <= wr_res;
         end
      end
   end

   // a cared-for bit that differs kills the match
   assign hit = on_q && ~|((key ^ val_q) & care_q);
   assign res = res_q;

endmodule

// File: rtl/lkp_prio_enc.sv
module lkp_prio_enc #(
   parameter int unsigned NUM_ENTRIES = 16,
   parameter int unsigned ENC_STYLE   = 1,
   parameter int unsigned ADDR_W      = $clog2(NUM_ENTRIES)
) (
   input  logic [NUM_ENTRIES-1:0] hit,
   output logic                   found,
   output logic [ADDR_W-1:0]      idx
);

   if (ENC_STYLE > 1) begin : g_bad_style
      $error("lkp_prio_enc: ENC_STYLE must be 0 (linear) or 1 (tree)");
   end

   if (ENC_STYLE == 0) begin : g_linear
      // scan from the top so the lowest hit is the last one written
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
               found = 1'b1;
               idx   = ADDR_W'(i);
            end
         end
      end
   end else begin : g_tree
      localparam int unsigned LEAVES = 1 << ADDR_W;
      localparam int unsigned NODES  = 2 * LEAVES - 1;

      // heap layout: node n has children 2n+1 (lower indices) and 2n+2
      for (genvar n = 0; n < NODES; n++) begin : g_node
         logic              f;
         logic [ADDR_W-1:0] x;
         if (n >= LEAVES - 1) begin : g_leaf
            if (n - (LEAVES - 1) < NUM_ENTRIES) begin : g_live
               assign f = hit[n - (LEAVES - 1)];
            end else begin : g_pad
               assign f = 1'b0;
            end
            assign x = ADDR_W'(n - (LEAVES - 1));
         end else begin : g_join
            assign f = g_node[2*n+1].f | g_node[2*n+2].f;
            assign x = g_node[2*n+1].f ? g_node[2*n+1].x : g_node[2*n+2].x;
         end
      end

      assign found = g_node[0].f;
      assign idx   = g_node[0].x;
   end

endmodule

// File: rtl/lkp_prio_lookup.sv
module lkp_prio_lookup
   import lkp_pkg::*;
#(
   parameter int unsigned KEY_W       = 144,
   parameter int unsigned NUM_ENTRIES = 16,
   parameter int unsigned EXC_W       = 12,
   parameter int unsigned ENC_STYLE   = 1,
   localparam int unsigned ADDR_W     = $clog2(NUM_ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_op,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [KEY_W-1:0]   cfg_value,
   input  logic [KEY_W-1:0]   cfg_care,
   input  logic               cfg_res_mc,
   input  logic [30:0]        cfg_res_idx,
   input  logic [15:0]        cfg_res_cmask,
   input  logic [15:0]        cfg_res_stat,
   input  logic               lk_valid,
   output logic               lk_ready,
   input  logic [KEY_W-1:0]   lk_key,
   input  logic [EXC_W-1:0]   lk_exc,
   output logic               rs_valid,
   input  logic               rs_ready,
   output logic               rs_mc,
   output logic [30:0]        rs_idx,
   output logic [15:0]        rs_cmask,
   output logic [15:0]        rs_stat,
   output logic [EXC_W-1:0]   rs_exc,
   output logic               rs_drop
);

   localparam int unsigned TAG_W = 32;

   if (NUM_ENTRIES < 2) begin : g_bad_depth
      $error("lkp_prio_lookup: NUM_ENTRIES must be at least 2");
   end
   if (KEY_W <= TAG_W) begin : g_bad_key
      $error("lkp_prio_lookup: KEY_W must leave room for a user field below the tag");
   end
   if (EXC_W < 1) begin : g_bad_exc
      $error("lkp_prio_lookup: EXC_W must be at least 1");
   end

   // ---------------- table write decode ----------------
   cfg_op_e     op_e;
   lkp_result_t wr_res;
   assign op_e   = cfg_op_e'(cfg_op);
   assign wr_res = '{mc: cfg_res_mc, ridx: cfg_res_idx,
                     cmask: cfg_res_cmask, stat: cfg_res_stat};

   logic [NUM_ENTRIES-1:0] hit_vec;
   lkp_result_t            res_arr [NUM_ENTRIES];

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      logic addr_hit;
      assign addr_hit = cfg_we && (cfg_addr == ADDR_W'(i));

      lkp_ternary_cell #(.KEY_W(KEY_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_key  (addr_hit && (op_e == CFG_KEY)),
         .sel_res  (addr_hit && (op_e == CFG_RESULT)),
         .sel_off  (addr_hit && (op_e == CFG_DISABLE)),
         .wr_value (cfg_value),
         .wr_care  (cfg_care),
         .wr_res   (wr_res),
         .key      (lk_key),
         .hit      (hit_vec[i]),
         .res      (res_arr[i])
      );
   end

   // ---------------- priority resolution ----------------
   logic              win_found;
   logic [ADDR_W-1:0] win_idx;

   lkp_prio_enc #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .ENC_STYLE   (ENC_STYLE),
      .ADDR_W      (ADDR_W)
   ) u_enc (
      .hit   (hit_vec),
      .found (win_found),
      .idx   (win_idx)
   );

   lkp_result_t win_res;
   lkp_result_t fmt_res;

   always_comb begin
      win_res = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (win_found && (win_idx == ADDR_W'(i))) begin
            win_res = res_arr[i];
         end
      end
      fmt_res = win_res;
      if (!fmt_res.mc) begin
         fmt_res.cmask = '0;
      end
   end

   // ---------------- two-stage pipeline ----------------
   logic             s1_v;
   logic             s1_hit;
   lkp_result_t      s1_res;
   logic [EXC_W-1:0] s1_exc;

   logic             out_v_q;
   lkp_result_t      out_res_q;
   logic [EXC_W-1:0] out_exc_q;
   logic             drop_q;
   logic             out_free;

   assign out_free = !out_v_q || rs_ready;
   assign lk_ready = !s1_v || out_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_hit    <= 1'b0;
         s1_res    <= '0;
         s1_exc    <= '0;
         out_v_q   <= 1'b0;
         out_res_q <= '0;
         out_exc_q <= '0;
         drop_q    <= 1'b0;
      end else begin
         if (lk_ready) begin
            s1_v <= lk_valid;
            if (lk_valid) begin
               s1_hit <= win_found;
               s1_res <= fmt_res;
               s1_exc <= lk_exc;
            end
         end
         if (out_free) begin
            out_v_q <= s1_v && s1_hit;
            if (s1_v && s1_hit) begin
               out_res_q <= s1_res;
               out_exc_q <= s1_exc;
            end
         end
         drop_q <= s1_v && !s1_hit && out_free;
      end
   end

   assign rs_valid = out_v_q;
   assign rs_mc    = out_res_q.mc;
   assign rs_idx   = out_res_q.ridx;
   assign rs_cmask = out_res_q.cmask;
   assign rs_stat  = out_res_q.stat;
   assign rs_exc   = out_exc_q;
   assign rs_drop  = drop_q;

endmodule

// File: rtl/lkp_lookup_chk.sv
module lkp_lookup_chk #(
   parameter int unsigned EXC_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_ready,
   input logic             rs_valid,
   input logic             rs_ready,
   input logic             rs_mc,
   input logic [30:0]      rs_idx,
   input logic [15:0]      rs_cmask,
   input logic [15:0]      rs_stat,
   input logic [EXC_W-1:0] rs_exc,
   input logic             rs_drop
);

   // keys accepted but not yet delivered or dropped
   logic [2:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 3'd0;
      end else begin
         pend_q <= pend_q + 3'(lk_valid && lk_ready)
                          - 3'(rs_valid && rs_ready)
                          - 3'(rs_drop);
      end
   end

   // R3
   drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rs_valid && rs_drop));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_mc) && $stable(rs_idx)
                                   && $stable(rs_cmask) && $stable(rs_stat)
                                   && $stable(rs_exc)));

   // R4
   uc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_mc) |-> (rs_cmask == 16'd0));

   // R6
   depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= 3'd2);

   // R6
   no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid || rs_drop) |-> (pend_q != 3'd0));

   // R7
   empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == 3'd0) |-> lk_ready);

endmodule

bind lkp_prio_lookup lkp_lookup_chk #(.EXC_W(EXC_W)) u_lkp_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_valid (lk_valid),
   .lk_ready (lk_ready),
   .rs_valid (rs_valid),
   .rs_ready (rs_ready),
   .rs_mc    (rs_mc),
   .rs_idx   (rs_idx),
   .rs_cmask (rs_cmask),
   .rs_stat  (rs_stat),
   .rs_exc   (rs_exc),
   .rs_drop  (rs_drop)
);

// File: tb/tb_lkp_prio_lookup.sv
module tb_lkp_prio_lookup;

   localparam int unsigned CLK_P = 10;
   localparam int unsigned N     = 8;
   localparam int unsigned KW    = 144;
   localparam int unsigned AW    = 3;
   localparam int unsigned XW    = 12;

   localparam logic [31:0] TAG_A = {1'b0, 4'h5, 11'h2AA, 16'd4791};
   localparam logic [31:0] TAG_B = {1'b0, 4'h5, 11'h2AB, 16'd4791};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_op = 2'b00;
   logic [AW-1:0] cfg_addr = '0;
   logic [KW-1:0] cfg_value = '0;
   logic [KW-1:0] cfg_care = '0;
   logic          cfg_res_mc = 1'b0;
   logic [30:0]   cfg_res_idx = '0;
   logic [15:0]   cfg_res_cmask = '0;
   logic [15:0]   cfg_res_stat = '0;
   logic          lk_valid = 1'b0;
   logic          lk_ready;
   logic [KW-1:0] lk_key = '0;
   logic [XW-1:0] lk_exc = '0;
   logic          rs_valid;
   logic          rs_ready = 1'b1;
   logic          rs_mc;
   logic [30:0]   rs_idx;
   logic [15:0]   rs_cmask;
   logic [15:0]   rs_stat;
   logic [XW-1:0] rs_exc;
   logic          rs_drop;

   int unsigned checks = 0;
   int unsigned errors = 0;

   always #(CLK_P/2) clk = ~clk;

   lkp_prio_lookup #(.KEY_W(KW), .NUM_ENTRIES(N), .EXC_W(XW), .ENC_STYLE(1)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_addr(cfg_addr),
      .cfg_value(cfg_value), .cfg_care(cfg_care),
      .cfg_res_mc(cfg_res_mc), .cfg_res_idx(cfg_res_idx),
      .cfg_res_cmask(cfg_res_cmask), .cfg_res_stat(cfg_res_stat),
      .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_key(lk_key), .lk_exc(lk_exc),
      .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_mc(rs_mc), .rs_idx(rs_idx),
      .rs_cmask(rs_cmask), .rs_stat(rs_stat), .rs_exc(rs_exc), .rs_drop(rs_drop)
   );

   // ---------------- expected-value model ----------------
   function automatic logic [30:0] e_idx(int e, int g);
      return 31'(1000 + 7 * e + 100000 * g);
   endfunction
   function automatic logic [15:0] e_stat(int e, int g);
      return 16'(80 + e + 256 * g);
   endfunction
   function automatic logic e_mc(int e);
      return (e % 2) == 1;
   endfunction
   function automatic logic [15:0] e_wmask(int e, int g);
      return 16'(16'h0101 << e) | 16'(16'h8000 >> g);
   endfunction
   function automatic logic [KW-1:0] sweep_key(int b);
      return {{17{8'h3C}}, 8'(b)};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_key(input int a, input logic [KW-1:0] v, input logic [KW-1:0] c);
      cfg_we = 1'b1; cfg_op = 2'b01; cfg_addr = AW'(a); cfg_value = v; cfg_care = c;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_res(input int a, input int g);
      cfg_op = 2'b10; cfg_addr = AW'(a);
      cfg_res_mc = e_mc(a); cfg_res_idx = e_idx(a, g);
      cfg_res_cmask = e_wmask(a, g); cfg_res_stat = e_stat(a, g);
   endtask

   task automatic wr_res(input int a, input int g);
      cfg_we = 1'b1; set_res(a, g);
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr_off(input int a);
      cfg_we = 1'b1; cfg_op = 2'b11; cfg_addr = AW'(a);
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic expect_beat(input int ent, input int gen, input logic [XW-1:0] exc,
                              input string req);
      if (ent < 0) begin
         check(req, "miss gives drop only {valid,drop}", {62'd0, rs_valid, rs_drop}, 64'd1);
      end else begin
         check(req, "hit gives result only {valid,drop}", {62'd0, rs_valid, rs_drop}, 64'd2);
         check("R4", "result index", 64'(rs_idx), 64'(e_idx(ent, gen)));
         check("R4", "stats index", 64'(rs_stat), 64'(e_stat(ent, gen)));
         check("R4", "type bit", 64'(rs_mc), 64'(e_mc(ent)));
         check("R4", "copy mask", 64'(rs_cmask),
               e_mc(ent) ? 64'(e_wmask(ent, gen)) : 64'd0);
         check("R5", "exception bits", 64'(rs_exc), 64'(exc));
      end
   endtask

   // drive one key into an empty pipeline and check the beat two edges later
   task automatic look(input logic [KW-1:0] key, input logic [XW-1:0] exc,
                       input int ent, input int gen, input string req);
      lk_valid = 1'b1; lk_key = key; lk_exc = exc;
      @(posedge clk); @(negedge clk);
      lk_valid = 1'b0;
      check("R6", "nothing one edge after accept", {62'd0, rs_valid, rs_drop}, 64'd0);
      @(posedge clk); @(negedge clk);
      expect_beat(ent, gen, exc, req);
   endtask

   initial begin
      #(CLK_P * 50000);
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11", "rs_valid after reset", 64'(rs_valid), 64'd0);
      check("R11", "rs_drop after reset", 64'(rs_drop), 64'd0);
      check("R11", "lk_ready after reset", 64'(lk_ready), 64'd1);
      look('0, 12'h001, -1, 0, "R11");
      look({KW{1'b1}}, 12'h002, -1, 0, "R11");

      // R8: result writes alone leave entries disabled
      for (int i = 0; i < N; i++) wr_res(i, 0);
      look(sweep_key(8'hFF), 12'h003, -1, 0, "R8");

      // entry i cares only about key bit i
      for (int i = 0; i < N; i++)
         wr_key(i, {{17{8'hC3}}, 8'h5A | (8'h01 << i)}, 144'(1) << i);

      // R1 R2 R3 exhaustive sweep of matching subsets
      for (int b = 0; b < 256; b++) begin
         int win = -1;
         for (int j = N - 1; j >= 0; j--) if (b[j]) win = j;
         look(sweep_key(b), 12'(b * 13 + 5), win, 0, (win < 0) ? "R3" : "R2");
      end

      // R10 exception-path key: tag followed by zero user field
      wr_key(3, {TAG_A, {14{8'hE7}}}, {32'hFFFF_FFFF, 112'd0});
      look({TAG_A, 112'd0}, 12'hABC, 3, 0, "R10");
      look({TAG_B, 112'd0}, 12'hABD, -1, 0, "R10");
      // R2 entries 3, 4, 5 all match; 3 wins
      look({TAG_A, 104'd0, 8'h30}, 12'h111, 3, 0, "R2");

      // R8 disable then re-enable keeps the result
      wr_off(3);
      look({TAG_A, 112'd0}, 12'h222, -1, 0, "R8");
      look({TAG_A, 104'd0, 8'h30}, 12'h223, 4, 0, "R8");
      wr_key(3, {TAG_A, {14{8'hE7}}}, {32'hFFFF_FFFF, 112'd0});
      look({TAG_A, 112'd0}, 12'h224, 3, 0, "R8");
      // R8 result replace keeps the key
      wr_res(3, 1);
      look({TAG_A, 112'd0}, 12'h225, 3, 1, "R8");
      // R8 no-op write changes nothing
      cfg_we = 1'b1; cfg_op = 2'b00; cfg_addr = 3'd3; cfg_care = '0;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      look({TAG_A, 112'd0}, 12'h226, 3, 1, "R8");

      // R9 result write on the accepting edge is not seen
      cfg_we = 1'b1; set_res(3, 2);
      lk_valid = 1'b1; lk_key = {TAG_A, 112'd0}; lk_exc = 12'h333;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0; lk_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      expect_beat(3, 1, 12'h333, "R9");
      look({TAG_A, 112'd0}, 12'h334, 3, 2, "R9");
      // R9 disable on the accepting edge is not seen
      cfg_we = 1'b1; cfg_op = 2'b11; cfg_addr = 3'd3;
      lk_valid = 1'b1; lk_key = {TAG_A, 112'd0}; lk_exc = 12'h335;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0; lk_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      expect_beat(3, 2, 12'h335, "R9");
      look({TAG_A, 112'd0}, 12'h336, -1, 0, "R9");

      // R7 backpressure: two keys in flight, output held, order kept
      rs_ready = 1'b0;
      lk_valid = 1'b1; lk_key = sweep_key(8'h02); lk_exc = 12'h401;
      @(posedge clk); @(negedge clk);
      check("R7", "ready with output stage empty", 64'(lk_ready), 64'd1);
      lk_key = sweep_key(8'h04); lk_exc = 12'h402;
      @(posedge clk); @(negedge clk);
      lk_valid = 1'b0;
      check("R7", "ready low with both stages full", 64'(lk_ready), 64'd0);
      expect_beat(1, 0, 12'h401, "R7");
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); @(negedge clk);
         expect_beat(1, 0, 12'h401, "R7");
         check("R7", "ready stays low while stalled", 64'(lk_ready), 64'd0);
      end
      rs_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      expect_beat(2, 0, 12'h402, "R6");
      @(posedge clk); @(negedge clk);
      check("R6", "pipeline drained", {62'd0, rs_valid, rs_drop}, 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule